// File: doc/BRIEF.md
# Packed 4:2:2 YUV to RGB Colour Converter

This block turns a stream of packed 4:2:2 words into a stream of 8-bit RGB pixels. Every 32-bit input word carries two luma samples that share one pair of chroma samples. The block splits each word into two pixels and emits them in order. Each pixel then passes through a programmable 3x4 fixed-point colour matrix. A small write-only configuration port sets the twelve matrix words, the byte order inside a packed word, and the enable. When the enable is clear, the matrix is bypassed.

Both the input and the output use valid/ready handshakes. Words may be applied back to back. The block sustains one word every two cycles, which is one pixel per cycle. It has a fixed three-cycle latency whenever the output is not stalled. The configuration that applies to a word is captured at the edge where the word is accepted. Reprogramming never splits a word between two configurations.

Top module: `yuv422_rgb_conv`

## Requirements
- R1: After reset, out_valid is low and in_ready is high. The control register is 0, so the order code is 0 and conversion is disabled. The matrix words reset to a BT.601 limited-range set:
  - G row: 0x4A7, 0x1E6F, 0x1CBF, 0x877
  - R row: 0x4A7, 0x000, 0x662, 0x3211
  - B row: 0x4A7, 0x812, 0x000, 0x2EB1
- R2: Each channel is computed as follows:
  - Form the sum m_y*Y + m_u*U + m_v*V + (k << 6) + 512 at full precision.
  - The multipliers m are the low 13 bits of their word, read as two's complement, in units of 1/1024. The constant k is all 14 bits, read as two's complement, in units of 1/16.
  - Shift the sum right arithmetically by 10 bits.
- R3: Configuration address 4*row + col selects a matrix word.
  - Rows: 0 = G, 1 = R, 2 = B.
  - Columns: 0 = Y multiplier, 1 = U multiplier, 2 = V multiplier, 3 = constant.
  - out_rgb[23:16] is R, [15:8] is G and [7:0] is B.
- R4: Address 12 is the control register. cfg_wdata[1:0] is the order code and cfg_wdata[2] is the enable. Writes to addresses 13 to 15 change nothing.
- R5: Let byte n be in_data[8n+7:8n]. The order codes place the samples as follows (bytes 0..3):
  - Code 0: V, Y0, U, Y1.
  - Code 1: U, Y0, V, Y1.
  - Code 2: Y0, V, Y1, U.
  - Code 3: Y0, U, Y1, V.
- R6: Both pixels of a word use the same U and V. The Y0 pixel is emitted before the Y1 pixel. No new word is accepted while the Y0 pixel is still held.
- R7: With out_ready held high, the Y0 pixel of a word accepted at edge N is presented after edge N+3 and not before. The Y1 pixel follows one cycle later. A continuous input gives one pixel per cycle with no gaps. in_ready is high only when the output can advance.
- R8: While out_valid is high and out_ready is low, out_rgb holds steady and no pixel is lost or repeated.
- R9: With the enable clear, the matrix is bypassed: R = Y, G = U, B = V of the pixel, with the same latency.
- R10: The matrix words, order code and enable are sampled when a word is accepted. A write made while that word is in flight does not affect either of its pixels.
- R11: A channel result below 0 gives 0, and a result above 255 gives 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 14 | Configuration write data |
| in_valid | input | 1 | Packed word valid |
| in_ready | output | 1 | Packed word accepted when high with in_valid |
| in_data | input | 32 | Packed 4:2:2 word |
| out_valid | output | 1 | RGB pixel valid |
| out_ready | input | 1 | Downstream can take a pixel |
| out_rgb | output | 24 | R, G, B pixel |

## Verification
On every cycle, the assertions check several handshake and timing rules:
- an output stalled by out_ready holds its value and stays valid;
- no word is taken while the first pixel of the previous word is pending;
- in_ready never rises while the output is blocked;
- the captured matrix set changes only at a word acceptance;
- the block is idle while in reset.

Only the directed scenarios can show the arithmetic itself. These scenarios cover the reset matrix values, the four byte orders, bypass, saturation at both ends, the ignored addresses, the exact latency and gap-free throughput, and the immunity of an in-flight word to a mid-flight write.

// File: rtl/yuvc_pkg.sv
package yuvc_pkg;

  localparam int NROW  = 3;
  localparam int NMUL  = 3;
  localparam int NCOL  = NMUL + 1;
  localparam int NCOEF = NROW * NCOL;

  localparam int ROW_G = 0;
  localparam int ROW_R = 1;
  localparam int ROW_B = 2;

  localparam int CTRL_ADDR = NCOEF;

  // Names give the left-to-right sample sequence of bytes 0..3.
  typedef enum logic [1:0] {
    SEQ_VYUY = 2'd0,
    SEQ_UYVY = 2'd1,
    SEQ_YVYU = 2'd2,
    SEQ_YUYV = 2'd3
  } seq_e;

  typedef struct packed {
    logic [1:0] y0;
    logic [1:0] y1;
    logic [1:0] u;
    logic [1:0] v;
  } lane_map_t;

  function automatic lane_map_t lane_map(seq_e s);
    lane_map_t m;
    case (s)
      SEQ_VYUY: m = '{y0: 2'd1, y1: 2'd3, u: 2'd2, v: 2'd0};
      SEQ_UYVY: m = '{y0: 2'd1, y1: 2'd3, u: 2'd0, v: 2'd2};
      SEQ_YVYU: m = '{y0: 2'd0, y1: 2'd2, u: 2'd3, v: 2'd1};
      default:  m = '{y0: 2'd0, y1: 2'd2, u: 2'd1, v: 2'd3};
    endcase
    return m;
  endfunction

  // Reset matrix: limited-range BT.601 to full-range RGB.
  function automatic logic [15:0] bt601_word(int idx);
    logic [15:0] w;
    case (idx)
      0:       w = 16'h04A7;
      1:       w = 16'h1E6F;
      2:       w = 16'h1CBF;
      3:       w = 16'h0877;
      4:       w = 16'h04A7;
      5:       w = 16'h0000;
      6:       w = 16'h0662;
      7:       w = 16'h3211;
      8:       w = 16'h04A7;
      9:       w = 16'h0812;
      10:      w = 16'h0000;
      default: w = 16'h2EB1;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/yuvc_regs.sv
module yuvc_regs
  import yuvc_pkg::*;
#(
  parameter int AW = 4,
  parameter int MW = 13,
  parameter int KW = 14
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [AW-1:0]                   addr,
  input  logic [KW-1:0]                   wdata,
  output logic [NROW-1:0][NMUL-1:0][MW-1:0] mul,
  output logic [NROW-1:0][KW-1:0]         kon,
  output logic [1:0]                      seq,
  output logic                            en
);

  logic [1:0] seq_q, seq_d;
  logic       en_q, en_d;
  logic       ctrl_hit;

  for (genvar r = 0; r < NROW; r++) begin : g_row
    for (genvar c = 0; c < NMUL; c++) begin : g_mul
      localparam logic [15:0] RV = bt601_word(r * NCOL + c);
      logic          hit;
      logic [MW-1:0] q, d;

      always_comb begin
        hit = we && (addr == AW'(r * NCOL + c));
        d   = hit ? wdata[MW-1:0] : q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RV[MW-1:0];
        else        q <= d;
      end

      assign mul[r][c] = q;
    end

    localparam logic [15:0] KV = bt601_word(r * NCOL + NMUL);
    logic          khit;
    logic [KW-1:0] kq, kd;

    always_comb begin
      khit = we && (addr == AW'(r * NCOL + NMUL));
      kd   = khit ? wdata : kq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) kq <= KV[KW-1:0];
      else        kq <= kd;
    end

    assign kon[r] = kq;
  end

  always_comb begin
    ctrl_hit = we && (addr == AW'(CTRL_ADDR));
    seq_d    = ctrl_hit ? wdata[1:0] : seq_q;
    en_d     = ctrl_hit ? wdata[2]   : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= 2'd0;
      en_q  <= 1'b0;
    end else begin
      seq_q <= seq_d;
      en_q  <= en_d;
    end
  end

  assign seq = seq_q;
  assign en  = en_q;

endmodule

// File: rtl/yuvc_unpack.sv
module yuvc_unpack
  import yuvc_pkg::*;
#(
  parameter int SW = 8,
  parameter int MW = 13,
  parameter int KW = 14
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              adv,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [4*SW-1:0]                   in_data,
  input  logic [NROW-1:0][NMUL-1:0][MW-1:0] mul_in,
  input  logic [NROW-1:0][KW-1:0]           kon_in,
  input  logic [1:0]                        seq_in,
  input  logic                              en_in,
  output logic                              h_valid,
  output logic                              h_phase,
  output logic [NROW-1:0][NMUL-1:0][MW-1:0] h_mul,
  output logic [NROW-1:0][KW-1:0]           h_kon,
  output logic                              pix_byp,
  output logic [SW-1:0]                     pix_y,
  output logic [SW-1:0]                     pix_u,
  output logic [SW-1:0]                     pix_v
);

  logic            valid_d, phase_d, take;
  logic [4*SW-1:0] h_word;
  logic [1:0]      h_seq;
  logic            h_en;
  logic [3:0][SW-1:0] lanes;
  lane_map_t       lm;

  assign in_ready = adv && (!h_valid || h_phase);
  assign take     = in_valid && in_ready;

  always_comb begin
    valid_d = h_valid;
    phase_d = h_phase;
    if (adv) begin
      if (h_valid && !h_phase) begin
        phase_d = 1'b1;
      end else if (take) begin
        valid_d = 1'b1;
        phase_d = 1'b0;
      end else begin
        valid_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_valid <= 1'b0;
      h_phase <= 1'b0;
    end else begin
      h_valid <= valid_d;
      h_phase <= phase_d;
    end
  end

  // Word and its configuration snapshot, loaded only on acceptance.
  always_ff @(posedge clk) begin
    if (take) begin
      h_word <= in_data;
      h_mul  <= mul_in;
      h_kon  <= kon_in;
      h_seq  <= seq_in;
      h_en   <= en_in;
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign lanes[i] = h_word[i*SW +: SW];
  end

  always_comb begin
    lm      = lane_map(seq_e'(h_seq));
    pix_y   = h_phase ? lanes[lm.y1] : lanes[lm.y0];
    pix_u   = lanes[lm.u];
    pix_v   = lanes[lm.v];
    pix_byp = !h_en;
  end

endmodule

// File: rtl/yuvc_chan.sv
module yuvc_chan #(
  parameter int SW    = 8,
  parameter int MW    = 13,
  parameter int KW    = 14,
  parameter int FRAC  = 10,
  parameter int KFRAC = 4
) (
  input  logic                clk,
  input  logic                adv,
  input  logic [SW-1:0]       y,
  input  logic [SW-1:0]       u,
  input  logic [SW-1:0]       v,
  input  logic [2:0][MW-1:0]  mul,
  input  logic [KW-1:0]       kon,
  input  logic                byp,
  input  logic [SW-1:0]       byp_val,
  output logic [SW-1:0]       res
);

  localparam int PW   = MW + SW + 1;
  localparam int SUMW = PW + 3;
  localparam int KSH  = FRAC - KFRAC;
  localparam logic signed [SUMW-1:0] RND  = SUMW'(1) <<< (FRAC - 1);
  localparam logic signed [SUMW-1:0] MAXV = SUMW'((1 << SW) - 1);

  logic [SW-1:0]           smp [3];
  logic signed [PW-1:0]    prod_d [3];
  logic signed [PW-1:0]    prod_q [3];
  logic signed [KW-1:0]    kon_q;
  logic                    byp_m, byp_s;
  logic [SW-1:0]           bv_m, bv_s;
  logic signed [SUMW-1:0]  sum_d, sum_q, sh;
  logic [SW-1:0]           res_d, res_q;

  // Stage 1: products
  always_comb begin
    smp[0] = y;
    smp[1] = u;
    smp[2] = v;
    for (int i = 0; i < 3; i++) begin
      prod_d[i] = PW'($signed(mul[i])) * PW'($signed({1'b0, smp[i]}));
    end
  end

  // Stage 2: sum with aligned constant and rounding term
  always_comb begin
    sum_d = SUMW'(prod_q[0]) + SUMW'(prod_q[1]) + SUMW'(prod_q[2])
          + (SUMW'(kon_q) <<< KSH) + RND;
  end

  // Stage 3: scale and clamp, or bypass
  always_comb begin
    sh = sum_q >>> FRAC;
    if (byp_s)          res_d = bv_s;
    else if (sh < 0)    res_d = '0;
    else if (sh > MAXV) res_d = MAXV[SW-1:0];
    else                res_d = sh[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int i = 0; i < 3; i++) prod_q[i] <= prod_d[i];
      kon_q <= $signed(kon);
      byp_m <= byp;
      bv_m  <= byp_val;
      sum_q <= sum_d;
      byp_s <= byp_m;
      bv_s  <= bv_m;
      res_q <= res_d;
    end
  end

  assign res = res_q;

endmodule

// File: rtl/yuv422_rgb_conv.sv
module yuv422_rgb_conv
  import yuvc_pkg::*;
#(
  parameter int SW   = 8,
  parameter int MW   = 13,
  parameter int KW   = 14,
  parameter int AW   = 4,
  parameter int FRAC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [KW-1:0]    cfg_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [4*SW-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [3*SW-1:0]  out_rgb
);

  localparam int KFRAC = 4;

  logic [1:0] rst_sync;
  logic       rst_ns;
  logic       adv;

  logic [NROW-1:0][NMUL-1:0][MW-1:0] cfg_mul, hold_mul;
  logic [NROW-1:0][KW-1:0]           cfg_kon, hold_kon;
  logic [1:0]                        cfg_seq;
  logic                              cfg_en;
  logic                              hold_valid, hold_phase;
  logic                              pix_byp;
  logic [SW-1:0]                     pix_y, pix_u, pix_v;
  logic [SW-1:0]                     byp_val [NROW];
  logic [SW-1:0]                     res [NROW];
  logic                              m_valid, s_valid, o_valid;
  logic                              m_valid_d, s_valid_d, o_valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  assign adv = rst_ns && (!o_valid || out_ready);

  yuvc_regs #(.AW(AW), .MW(MW), .KW(KW)) u_regs (
    .clk   (clk),
    .rst_n (rst_ns),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .mul   (cfg_mul),
    .kon   (cfg_kon),
    .seq   (cfg_seq),
    .en    (cfg_en)
  );

  yuvc_unpack #(.SW(SW), .MW(MW), .KW(KW)) u_unpack (
    .clk      (clk),
    .rst_n    (rst_ns),
    .adv      (adv),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .mul_in   (cfg_mul),
    .kon_in   (cfg_kon),
    .seq_in   (cfg_seq),
    .en_in    (cfg_en),
    .h_valid  (hold_valid),
    .h_phase  (hold_phase),
    .h_mul    (hold_mul),
    .h_kon    (hold_kon),
    .pix_byp  (pix_byp),
    .pix_y    (pix_y),
    .pix_u    (pix_u),
    .pix_v    (pix_v)
  );

  for (genvar r = 0; r < NROW; r++) begin : g_chan
    if (r == ROW_R)      begin : g_br assign byp_val[r] = pix_y; end
    else if (r == ROW_G) begin : g_bg assign byp_val[r] = pix_u; end
    else                 begin : g_bb assign byp_val[r] = pix_v; end

    yuvc_chan #(.SW(SW), .MW(MW), .KW(KW), .FRAC(FRAC), .KFRAC(KFRAC)) u_chan (
      .clk     (clk),
      .adv     (adv),
      .y       (pix_y),
      .u       (pix_u),
      .v       (pix_v),
      .mul     (hold_mul[r]),
      .kon     (hold_kon[r]),
      .byp     (pix_byp),
      .byp_val (byp_val[r]),
      .res     (res[r])
    );
  end

  always_comb begin
    m_valid_d = m_valid;
    s_valid_d = s_valid;
    o_valid_d = o_valid;
    if (adv) begin
      m_valid_d = hold_valid;
      s_valid_d = m_valid;
      o_valid_d = s_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      m_valid <= 1'b0;
      s_valid <= 1'b0;
      o_valid <= 1'b0;
    end else begin
      m_valid <= m_valid_d;
      s_valid <= s_valid_d;
      o_valid <= o_valid_d;
    end
  end

  assign out_valid = o_valid;
  assign out_rgb   = {res[ROW_R], res[ROW_G], res[ROW_B]};

endmodule

// File: rtl/yuvc_chk.sv
module yuvc_chk
  import yuvc_pkg::*;
#(
  parameter int SW = 8,
  parameter int MW = 13,
  parameter int KW = 14
) (
  input logic                              clk,
  input logic                              rst_ns,
  input logic                              in_valid,
  input logic                              in_ready,
  input logic                              out_valid,
  input logic                              out_ready,
  input logic [3*SW-1:0]                   out_rgb,
  input logic                              hold_valid,
  input logic                              hold_phase,
  input logic [NROW-1:0][NMUL-1:0][MW-1:0] hold_mul,
  input logic [NROW-1:0][KW-1:0]           hold_kon
);

  // R1: idle while reset is applied
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_ns |-> (!out_valid && !in_ready));

  // R6: no word taken while the first pixel is pending
  a_r6_pair_block: assert property (@(posedge clk) disable iff (!rst_ns)
    (hold_valid && !hold_phase) |-> !in_ready);

  // R7: input only accepted when the output can move
  a_r7_backpressure: assert property (@(posedge clk) disable iff (!rst_ns)
    in_ready |-> (!out_valid || out_ready));

  // R8: stalled output holds
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));

  // R10: captured matrix changes only at a word acceptance
  a_r10_snapshot: assert property (@(posedge clk) disable iff (!rst_ns)
    !(in_valid && in_ready) |=> ($stable(hold_mul) && $stable(hold_kon)));

endmodule

bind yuv422_rgb_conv yuvc_chk #(.SW(SW), .MW(MW), .KW(KW)) u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_rgb    (out_rgb),
  .hold_valid (hold_valid),
  .hold_phase (hold_phase),
  .hold_mul   (hold_mul),
  .hold_kon   (hold_kon)
);

// File: tb/test_yuv422_rgb_conv.sv
`timescale 1ns/1ps
module test_yuv422_rgb_conv;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [13:0] cfg_wdata;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [23:0] out_rgb;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [13:0] bm_coef [12];
  logic [1:0]  bm_seq;
  logic        bm_en;

  always #4 clk = ~clk;

  yuv422_rgb_conv i_yuv422_rgb_conv (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_rgb   (out_rgb)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model(logic [31:0] w, bit ph);
    logic [7:0] b [4];
    logic [7:0] ch [3];
    int y, u, v, acc;
    for (int i = 0; i < 4; i++) b[i] = w[i*8 +: 8];
    case (bm_seq)
      2'd0: begin v = b[0]; u = b[2]; y = ph ? b[3] : b[1]; end
      2'd1: begin u = b[0]; v = b[2]; y = ph ? b[3] : b[1]; end
      2'd2: begin v = b[1]; u = b[3]; y = ph ? b[2] : b[0]; end
      default: begin u = b[1]; v = b[3]; y = ph ? b[2] : b[0]; end
    endcase
    if (!bm_en) return {y[7:0], u[7:0], v[7:0]};
    for (int r = 0; r < 3; r++) begin
      acc = int'($signed(bm_coef[4*r][12:0])) * y
          + int'($signed(bm_coef[4*r+1][12:0])) * u
          + int'($signed(bm_coef[4*r+2][12:0])) * v
          + int'($signed(bm_coef[4*r+3])) * 64 + 512;
      acc = acc >>> 10;
      ch[r] = (acc < 0) ? 8'd0 : (acc > 255) ? 8'd255 : acc[7:0];
    end
    return {ch[1], ch[0], ch[2]};
  endfunction

  task automatic wr(logic [3:0] a, logic [13:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 4'd12) bm_coef[a] = d;
    else if (a == 4'd12) begin bm_seq = d[1:0]; bm_en = d[2]; end
  endtask

  task automatic run_word(logic [31:0] w, string tag, bit mid = 0,
                          logic [3:0] ma = 0, logic [13:0] md = 0);
    logic [23:0] e0, e1;
    e0 = model(w, 0);
    e1 = model(w, 1);
    @(negedge clk);
    in_valid = 1'b1; in_data = w; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (mid) begin cfg_we = 1'b1; cfg_addr = ma; cfg_wdata = md; end
    @(negedge clk);
    if (mid) begin
      cfg_we = 1'b0;
      if (ma < 4'd12) bm_coef[ma] = md;
    end
    @(negedge clk);
    chk(!out_valid, "R7 early", 32'(out_valid), 0);
    @(negedge clk);
    chk(out_valid && out_rgb == e0, {tag, " pix0"}, 32'(out_rgb), 32'(e0));
    @(negedge clk);
    chk(out_valid && out_rgb == e1, {tag, " pix1 R6"}, 32'(out_rgb), 32'(e1));
    @(negedge clk);
    chk(!out_valid, {tag, " end"}, 32'(out_valid), 0);
  endtask

  function automatic logic [31:0] word_of(int i);
    return {8'(16 + i*29), 8'(40 + i*53), 8'(200 - i*17), 8'(90 + i*11)};
  endfunction

  task automatic run_stream(int n, bit stall, string tag);
    logic [23:0] exp [16];
    logic [23:0] held;
    int wi = 0, oi = 0, cyc = 0, first = -1, last = -1;
    bit acc = 0, pend = 0;
    for (int i = 0; i < n; i++) begin
      exp[2*i]   = model(word_of(i), 0);
      exp[2*i+1] = model(word_of(i), 1);
    end
    while (oi < 2*n && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (acc) wi++;
      if (pend) chk(out_valid && out_rgb == held, "R8 hold", 32'(out_rgb), 32'(held));
      in_valid  = (wi < n);
      in_data   = word_of(wi);
      out_ready = stall ? (cyc % 3 != 0) : 1'b1;
      #1;
      acc  = in_valid && in_ready;
      pend = out_valid && !out_ready;
      held = out_rgb;
      if (out_valid && out_ready) begin
        chk(out_rgb == exp[oi], tag, 32'(out_rgb), 32'(exp[oi]));
        if (first < 0) first = cyc;
        last = cyc;
        oi++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    chk(oi == 2*n, {tag, " count"}, 32'(oi), 32'(2*n));
    if (!stall) chk(last - first == 2*n - 1, "R7 no gaps", 32'(last - first), 32'(2*n - 1));
  endtask

  task automatic t_reset();
    chk(!out_valid, "R1 out_valid", 32'(out_valid), 0);
    chk(in_ready, "R1 in_ready", 32'(in_ready), 1);
  endtask

  task automatic t_bypass();
    // R9: reset leaves conversion disabled
    run_word(32'hA1B2C3D4, "R9 bypass");
  endtask

  task automatic t_default();
    wr(4'd12, 14'h7);
    run_word(32'h80EB8010, "R1 R2 default");
    run_word(32'h40905AC0, "R2 default");
  endtask

  task automatic t_orders();
    for (int c = 0; c < 4; c++) begin
      wr(4'd12, 14'(4 | c));
      run_word(32'h50C89030, "R5 order");
    end
  endtask

  task automatic t_custom();
    for (int a = 0; a < 12; a++) wr(4'(a), 14'h0);
    wr(4'd0, 14'h0400);
    wr(4'd5, 14'h0400);
    wr(4'd10, 14'h0400);
    run_word(32'h50C89030, "R3 map");
    wr(4'd3, 14'h1FFF);
    wr(4'd4, 14'h1000);
    run_word(32'h50C89030, "R11 clamp");
  endtask

  task automatic t_mid();
    wr(4'd11, 14'h0100);
    run_word(32'h30608090, "R10 inflight", 1, 4'd11, 14'h3E00);
    run_word(32'h30608090, "R10 new");
  endtask

  task automatic t_ignore();
    wr(4'd13, 14'h0);
    wr(4'd14, 14'h0);
    wr(4'd15, 14'h0);
    run_word(32'h7788AA22, "R4 ignored");
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    bm_coef = '{14'h04A7, 14'h1E6F, 14'h1CBF, 14'h0877,
                14'h04A7, 14'h0000, 14'h0662, 14'h3211,
                14'h04A7, 14'h0812, 14'h0000, 14'h2EB1};
    bm_seq = 2'd0; bm_en = 1'b0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 in reset", 32'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bypass();
    t_default();
    t_orders();
    t_custom();
    t_mid();
    t_ignore();
    wr(4'd12, 14'h7);
    run_stream(5, 0, "R7 stream");
    run_stream(6, 1, "R8 stall");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule